// File: doc/BRIEF.md
# Paired fetch-address watch unit

This block raises debug events when instruction fetches hit programmed addresses. It holds two compare registers and a control word. Each of the two comparators has a privilege filter and an address-space filter. A pair-mode field either lets the comparators work apart, as two exact-address watches, or joins them into one checker. The joined checker can do a masked bit match, an inclusive range test or an exclusive range test. In a joined mode only the first comparator reports, and only the first comparator's filters apply.

Each cycle the core presents a fetch-valid strobe, the fetch address, the privilege bit (0 for supervisor, 1 for user) and the instruction-space bit. A qualified match produces a one-clock event pulse on the clock edge that samples the strobe. The control word is cleared in two ways. Power-on reset always clears it. Processor reset clears it fully when external debug ownership is off. When ownership is on, processor reset clears only the bits that a software-ownership mask selects.

Top module: `addr_pair_watch`

## Requirements
- R1: With pair mode 00, hit_a pulses when the fetch address equals compare register 1, and hit_b pulses when it equals compare register 2; the two work independently.
- R2: With pair mode 01, hit_a pulses when (address AND cmp2) equals (cmp1 AND cmp2); hit_b never pulses in modes 01, 10 or 11.
- R3: With pair mode 10, hit_a pulses when cmp1 <= address < cmp2, using unsigned comparison.
- R4: With pair mode 11, hit_a pulses when address < cmp1 or address >= cmp2, using unsigned comparison.
- R5: When cmp2 <= cmp1, mode 10 never matches and mode 11 matches every address.
- R6: The privilege filter takes these values: 00 = any state, 01 = never, 10 = only when fetch_pr=0, 11 = only when fetch_pr=1.
- R7: The address-space filter takes these values: 00 = any, 01 = never, 10 = only when fetch_is=0, 11 = only when fetch_is=1.
- R8: In modes 01, 10 and 11, only the comparator-1 filters gate hit_a, and the comparator-2 filters have no effect.
- R9: An event is a single-cycle pulse that appears one clock after a sampled fetch_vld=1. There is no event without fetch_vld.
- R10: Power-on reset (rst_por_n=0) clears the control word and both compare registers.
- R11: When processor reset (rst_cpu_n=0) is applied with dbg_own=0, the control word clears to zero.
- R12: When processor reset is applied with dbg_own=1, only the control bits set in own_mask are cleared, and the other bits keep their value.
- R13: The control word bits run from the MSB downward: bit 15:14 = comparator-1 privilege, bit 13:12 = comparator-1 space, bit 11:10 = comparator-2 privilege, bit 9:8 = comparator-2 space, bit 7:6 = pair mode. Bits 5:0 ignore writes and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_cpu_n | input | 1 | Processor reset, active low, synchronous |
| dbg_own | input | 1 | External debug ownership active |
| own_mask | input | CTL_W | Software-owned control bits, cleared by processor reset under ownership |
| ctl_we | input | 1 | Control word write enable |
| ctl_wdata | input | CTL_W | Control word write data |
| ctl_rdata | output | CTL_W | Current control word |
| cmp_we | input | 1 | Compare register write enable |
| cmp_sel | input | 1 | Compare register select (0 = cmp1, 1 = cmp2) |
| cmp_wdata | input | ADDR_W | Compare register write data |
| fetch_vld | input | 1 | Fetch valid strobe |
| fetch_addr | input | ADDR_W | Fetch address |
| fetch_pr | input | 1 | Privilege state (1 = user) |
| fetch_is | input | 1 | Instruction-space bit |
| hit_a | output | 1 | Comparator-1 event pulse |
| hit_b | output | 1 | Comparator-2 event pulse |

## Verification
The bound checker watches, on every cycle, a set of properties. Every event must follow a valid fetch. hit_b must stay silent in the joined modes and must only fire on exact equality. A reserved filter encoding must never let an event through. The reserved control bits must stay zero, and both processor-reset rules must hold. The bench's vector table covers the rest, which only concrete values can show. That includes the masked-match arithmetic, the range edges at cmp1 and cmp2, and the inverted-range cases. It also covers unsigned ordering across the sign bit, whether each filter lets events through, and the compare registers being cleared by power-on reset.

// File: rtl/awatch_pkg.sv
package awatch_pkg;
   typedef enum logic [1:0] {
      PM_EXACT    = 2'b00,
      PM_MASKED   = 2'b01,
      PM_INRANGE  = 2'b10,
      PM_OUTRANGE = 2'b11
   } pair_mode_e;

   // filter encodings shared by privilege and space fields
   localparam logic [1:0] FLT_ANY   = 2'b00;
   localparam logic [1:0] FLT_NEVER = 2'b01;
   localparam logic [1:0] FLT_LOW   = 2'b10;
   localparam logic [1:0] FLT_HIGH  = 2'b11;

   typedef struct packed {
      logic [1:0] priv;
      logic [1:0] space;
   } cmp_flt_t;

   // live control bits occupy the top of the word
   localparam int LIVE_W = 10;
endpackage

// File: rtl/awatch_ctl.sv
module awatch_ctl
   import awatch_pkg::*;
#(
   parameter int CTL_W = 16
) (
   input  logic             clk,
   input  logic             rst_por_n,
   input  logic             rst_cpu_n,
   input  logic             dbg_own,
   input  logic [CTL_W-1:0] own_mask,
   input  logic             we,
   input  logic [CTL_W-1:0] wdata,
   output logic [CTL_W-1:0] q
);
   localparam logic [CTL_W-1:0] LIVE_MASK =
      {{LIVE_W{1'b1}}, {(CTL_W-LIVE_W){1'b0}}};

   always_ff @(posedge clk or negedge rst_por_n) begin
      if (!rst_por_n) begin
         q <= '0;
      end else if (!rst_cpu_n) begin
         if (dbg_own) q <= q & ~own_mask;
         else         q <= '0;
      end else if (we) begin
         q <= wdata & LIVE_MASK;
      end
   end
endmodule

// File: rtl/awatch_cmpregs.sv
module awatch_cmpregs #(
   parameter int ADDR_W = 32,
   parameter int N_CMP  = 2
) (
   input  logic              clk,
   input  logic              rst_por_n,
   input  logic              we,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] val [N_CMP]
);
   localparam int SEL_W = (N_CMP > 1) ? $clog2(N_CMP) : 1;

   for (genvar i = 0; i < N_CMP; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_por_n) begin
         if (!rst_por_n)
            val[i] <= '0;
         else if (we && (SEL_W'(sel) == SEL_W'(i)))
            val[i] <= wdata;
      end
   end
endmodule

// File: rtl/awatch_flt.sv
module awatch_flt
   import awatch_pkg::*;
(
   input  cmp_flt_t flt,
   input  logic     pr,
   input  logic     is_bit,
   output logic     ok
);
   logic priv_ok, space_ok;

   always_comb begin
      unique case (flt.priv)
         FLT_ANY:   priv_ok = 1'b1;
         FLT_NEVER: priv_ok = 1'b0;
         FLT_LOW:   priv_ok = !pr;
         default:   priv_ok = pr;
      endcase
      unique case (flt.space)
         FLT_ANY:   space_ok = 1'b1;
         FLT_NEVER: space_ok = 1'b0;
         FLT_LOW:   space_ok = !is_bit;
         default:   space_ok = is_bit;
      endcase
      ok = priv_ok && space_ok;
   end
endmodule

// File: rtl/awatch_match.sv
module awatch_match
   import awatch_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  pair_mode_e        mode,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] c1,
   input  logic [ADDR_W-1:0] c2,
   output logic              m1,
   output logic              m2
);
   logic eq1, eq2, msk, ge1, lt2;

   always_comb begin
      eq1 = (addr == c1);
      eq2 = (addr == c2);
      msk = (((addr ^ c1) & c2) == '0);
      ge1 = (addr >= c1);
      lt2 = (addr < c2);
      m2  = 1'b0;
      unique case (mode)
         PM_EXACT: begin
            m1 = eq1;
            m2 = eq2;
         end
         PM_MASKED:  m1 = msk;
         PM_INRANGE: m1 = ge1 && lt2;
         default:    m1 = !ge1 || !lt2;
      endcase
   end
endmodule

// File: rtl/addr_pair_watch.sv
module addr_pair_watch
   import awatch_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CTL_W  = 16
) (
   input  logic              clk,
   input  logic              rst_por_n,
   input  logic              rst_cpu_n,
   input  logic              dbg_own,
   input  logic [CTL_W-1:0]  own_mask,
   input  logic              ctl_we,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   input  logic              cmp_we,
   input  logic              cmp_sel,
   input  logic [ADDR_W-1:0] cmp_wdata,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_pr,
   input  logic              fetch_is,
   output logic              hit_a,
   output logic              hit_b
);
   localparam int N_CMP    = 2;
   localparam int FLT_W    = $bits(cmp_flt_t);
   localparam int MODE_TOP = CTL_W - 1 - N_CMP * FLT_W;

   if (CTL_W <= LIVE_W) begin : g_bad_ctl
      $error("CTL_W must exceed the live control width");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic [CTL_W-1:0]  ctl_q;
   logic [ADDR_W-1:0] cmp_val [N_CMP];
   logic [ADDR_W-1:0] cmp1_q, cmp2_q;
   logic [N_CMP-1:0]  flt_ok;
   logic [N_CMP-1:0]  raw_m;
   logic [N_CMP-1:0]  hit_q;
   pair_mode_e        mode;

   awatch_ctl #(.CTL_W(CTL_W)) u_ctl (
      .clk       (clk),
      .rst_por_n (rst_por_n),
      .rst_cpu_n (rst_cpu_n),
      .dbg_own   (dbg_own),
      .own_mask  (own_mask),
      .we        (ctl_we),
      .wdata     (ctl_wdata),
      .q         (ctl_q)
   );

   awatch_cmpregs #(.ADDR_W(ADDR_W), .N_CMP(N_CMP)) u_regs (
      .clk       (clk),
      .rst_por_n (rst_por_n),
      .we        (cmp_we),
      .sel       (cmp_sel),
      .wdata     (cmp_wdata),
      .val       (cmp_val)
   );

   assign cmp1_q = cmp_val[0];
   assign cmp2_q = cmp_val[1];
   assign mode   = pair_mode_e'(ctl_q[MODE_TOP -: 2]);

   for (genvar i = 0; i < N_CMP; i++) begin : g_flt
      cmp_flt_t fld;
      assign fld = cmp_flt_t'(ctl_q[CTL_W-1-i*FLT_W -: FLT_W]);
      awatch_flt u_flt (
         .flt    (fld),
         .pr     (fetch_pr),
         .is_bit (fetch_is),
         .ok     (flt_ok[i])
      );
   end

   awatch_match #(.ADDR_W(ADDR_W)) u_match (
      .mode (mode),
      .addr (fetch_addr),
      .c1   (cmp1_q),
      .c2   (cmp2_q),
      .m1   (raw_m[0]),
      .m2   (raw_m[1])
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_hit
      always_ff @(posedge clk or negedge rst_por_n) begin
         if (!rst_por_n) hit_q[i] <= 1'b0;
         else            hit_q[i] <= fetch_vld && raw_m[i] && flt_ok[i];
      end
   end

   assign hit_a     = hit_q[0];
   assign hit_b     = hit_q[1];
   assign ctl_rdata = ctl_q;
endmodule

// File: rtl/awatch_chk.sv
module awatch_chk #(
   parameter int ADDR_W = 32,
   parameter int CTL_W  = 16
) (
   input logic              clk,
   input logic              rst_por_n,
   input logic              rst_cpu_n,
   input logic              dbg_own,
   input logic [CTL_W-1:0]  own_mask,
   input logic [CTL_W-1:0]  ctl_rdata,
   input logic [ADDR_W-1:0] cmp1_q,
   input logic [ADDR_W-1:0] cmp2_q,
   input logic              fetch_vld,
   input logic [ADDR_W-1:0] fetch_addr,
   input logic              hit_a,
   input logic              hit_b
);
   logic [1:0] priv1, space1, pmode;
   assign priv1  = ctl_rdata[CTL_W-1 -: 2];
   assign space1 = ctl_rdata[CTL_W-3 -: 2];
   assign pmode  = ctl_rdata[CTL_W-9 -: 2];

   assert_exact_b_R1: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_b |-> $past(fetch_addr) == $past(cmp2_q));

   assert_pair_quiet_R2: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_b |-> $past(pmode) == 2'b00);

   assert_inrange_R3: assert property (@(posedge clk) disable iff (!rst_por_n)
      (hit_a && $past(pmode) == 2'b10) |->
         ($past(fetch_addr) >= $past(cmp1_q) && $past(fetch_addr) < $past(cmp2_q)));

   assert_priv_never_R6: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_a |-> $past(priv1) != 2'b01);

   assert_space_never_R7: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_a |-> $past(space1) != 2'b01);

   assert_strobe_a_R9: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_a |-> $past(fetch_vld));

   assert_strobe_b_R9: assert property (@(posedge clk) disable iff (!rst_por_n)
      hit_b |-> $past(fetch_vld));

   assert_cpu_clear_R11: assert property (@(posedge clk) disable iff (!rst_por_n)
      $past(!rst_cpu_n && !dbg_own) |-> ctl_rdata == '0);

   assert_owned_clear_R12: assert property (@(posedge clk) disable iff (!rst_por_n)
      $past(!rst_cpu_n && dbg_own) |-> (ctl_rdata & $past(own_mask)) == '0);

   assert_rsvd_zero_R13: assert property (@(posedge clk) disable iff (!rst_por_n)
      ctl_rdata[CTL_W-11:0] == '0);
endmodule

bind addr_pair_watch awatch_chk #(.ADDR_W(ADDR_W), .CTL_W(CTL_W)) u_chk (
   .clk        (clk),
   .rst_por_n  (rst_por_n),
   .rst_cpu_n  (rst_cpu_n),
   .dbg_own    (dbg_own),
   .own_mask   (own_mask),
   .ctl_rdata  (ctl_rdata),
   .cmp1_q     (cmp1_q),
   .cmp2_q     (cmp2_q),
   .fetch_vld  (fetch_vld),
   .fetch_addr (fetch_addr),
   .hit_a      (hit_a),
   .hit_b      (hit_b)
);

// File: tb/sim_addr_pair_watch.sv
`timescale 1ns/1ps
module sim_addr_pair_watch;
   logic        clk = 1'b0;
   logic        rst_por_n = 1'b0, rst_cpu_n = 1'b1, dbg_own = 1'b0;
   logic [15:0] own_mask = '0;
   logic        ctl_we = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic [15:0] ctl_rdata;
   logic        cmp_we = 1'b0, cmp_sel = 1'b0;
   logic [31:0] cmp_wdata = '0;
   logic        fetch_vld = 1'b0, fetch_pr = 1'b0, fetch_is = 1'b0;
   logic [31:0] fetch_addr = '0;
   logic        hit_a, hit_b;
   int          total = 0, bad = 0, cyc = 0;

   always #4 clk = ~clk;

   addr_pair_watch u0 (.*);

   // control word builder: priv1, space1, priv2, space2, mode
   function automatic logic [15:0] cw(logic [1:0] p1, logic [1:0] s1,
                                      logic [1:0] p2, logic [1:0] s2, logic [1:0] m);
      return {p1, s1, p2, s2, m, 6'b0};
   endfunction

   typedef struct packed {
      logic [15:0] ctl;
      logic [31:0] c1;
      logic [31:0] c2;
      logic [31:0] addr;
      logic        pr;
      logic        isb;
      logic        ea;
      logic        eb;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{cw(0,0,0,0,0), 32'h100, 32'h200, 32'h100, 1'b0, 1'b0, 1'b1, 1'b0}, // R1
      '{cw(0,0,0,0,0), 32'h100, 32'h200, 32'h200, 1'b0, 1'b0, 1'b0, 1'b1}, // R1
      '{cw(0,0,0,0,0), 32'h300, 32'h300, 32'h300, 1'b0, 1'b0, 1'b1, 1'b1}, // R1
      '{cw(0,0,0,0,0), 32'h100, 32'h200, 32'h101, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
      '{cw(0,0,0,0,1), 32'h12340000, 32'hFFFF0000, 32'h1234ABCD, 1'b0, 1'b0, 1'b1, 1'b0}, // R2
      '{cw(0,0,0,0,1), 32'h12340000, 32'hFFFF0000, 32'h12350000, 1'b0, 1'b0, 1'b0, 1'b0}, // R2
      '{cw(0,0,0,0,1), 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0},                      // R2 (b silent on equal addr)
      '{cw(0,0,0,0,2), 32'h1000, 32'h2000, 32'h1000, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 low edge
      '{cw(0,0,0,0,2), 32'h1000, 32'h2000, 32'h1FFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R3
      '{cw(0,0,0,0,2), 32'h1000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0}, // R3 high edge
      '{cw(0,0,0,0,2), 32'h7FFFFFFF, 32'h80000001, 32'h80000000, 1'b0, 1'b0, 1'b1, 1'b0}, // R3 unsigned
      '{cw(0,0,0,0,3), 32'h1000, 32'h2000, 32'h0FFF, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
      '{cw(0,0,0,0,3), 32'h1000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4
      '{cw(0,0,0,0,3), 32'h1000, 32'h2000, 32'h1800, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
      '{cw(0,0,0,0,2), 32'h2000, 32'h2000, 32'h2000, 1'b0, 1'b0, 1'b0, 1'b0}, // R5
      '{cw(0,0,0,0,3), 32'h3000, 32'h1000, 32'h2000, 1'b0, 1'b0, 1'b1, 1'b0}, // R5
      '{cw(2,0,3,0,0), 32'h500, 32'h500, 32'h500, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 supervisor
      '{cw(2,0,3,0,0), 32'h500, 32'h500, 32'h500, 1'b1, 1'b0, 1'b0, 1'b1}, // R6 user
      '{cw(1,0,0,0,0), 32'h700, 32'h700, 32'h700, 1'b0, 1'b0, 1'b0, 1'b1}, // R6 reserved
      '{cw(0,2,0,3,0), 32'h600, 32'h600, 32'h600, 1'b0, 1'b0, 1'b1, 1'b0}, // R7 is=0
      '{cw(0,2,0,3,0), 32'h600, 32'h600, 32'h600, 1'b0, 1'b1, 1'b0, 1'b1}, // R7 is=1
      '{cw(0,1,0,0,0), 32'h700, 32'h700, 32'h700, 1'b0, 1'b0, 1'b0, 1'b1}, // R7 never
      '{cw(0,0,2,1,2), 32'h1000, 32'h2000, 32'h1800, 1'b1, 1'b0, 1'b1, 1'b0}, // R8 cmp2 filters ignored
      '{cw(3,0,0,0,2), 32'h1000, 32'h2000, 32'h1800, 1'b0, 1'b0, 1'b0, 1'b0}  // R8 cmp1 filter applies
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic write_all(logic [15:0] c, logic [31:0] a, logic [31:0] b);
      @(negedge clk);
      ctl_we = 1'b1; ctl_wdata = c;
      cmp_we = 1'b1; cmp_sel = 1'b0; cmp_wdata = a;
      @(negedge clk);
      ctl_we = 1'b0; cmp_sel = 1'b1; cmp_wdata = b;
      @(negedge clk);
      cmp_we = 1'b0;
   endtask

   task automatic fetch(logic [31:0] a, logic p, logic s, logic v);
      fetch_vld = v; fetch_addr = a; fetch_pr = p; fetch_is = s;
      @(negedge clk);
      fetch_vld = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         total++; bad++;
         $display("FAIL watchdog R9 actual=%0d expected<=20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: power-on reset state
      chk("R10 ctl after POR", 32'(ctl_rdata), 32'h0);
      chk("R10 hits after POR", {30'b0, hit_a, hit_b}, 32'h0);
      rst_por_n = 1'b1;
      @(negedge clk);

      // vector table
      for (int i = 0; i < NV; i++) begin
         write_all(VEC[i].ctl, VEC[i].c1, VEC[i].c2);
         fetch(VEC[i].addr, VEC[i].pr, VEC[i].isb, 1'b1);
         total++;
         if ({hit_a, hit_b} !== {VEC[i].ea, VEC[i].eb}) begin
            bad++;
            $display("FAIL vector %0d (R1..R8 table) actual=%b%b expected=%b%b",
                     i, hit_a, hit_b, VEC[i].ea, VEC[i].eb);
         end
         @(negedge clk);
         chk("R9 single-cycle pulse", {30'b0, hit_a, hit_b}, 32'h0);
      end

      // R9: no event without the strobe
      write_all(cw(0,0,0,0,0), 32'h40, 32'h40);
      fetch(32'h40, 1'b0, 1'b0, 1'b0);
      chk("R9 no strobe", {30'b0, hit_a, hit_b}, 32'h0);

      // R13: reserved bits ignore writes
      write_all(16'hFFFF, 32'h40, 32'h40);
      chk("R13 reserved read zero", 32'(ctl_rdata), 32'h0000FFC0);

      // R12: processor reset under ownership clears masked bits only
      @(negedge clk);
      dbg_own = 1'b1; own_mask = 16'hF000; rst_cpu_n = 1'b0;
      @(negedge clk);
      rst_cpu_n = 1'b1;
      chk("R12 owned clear", 32'(ctl_rdata), 32'h00000FC0);

      // R11: processor reset without ownership clears everything
      dbg_own = 1'b0; rst_cpu_n = 1'b0;
      @(negedge clk);
      rst_cpu_n = 1'b1;
      chk("R11 full clear", 32'(ctl_rdata), 32'h0);

      // R10: power-on reset clears compare registers too
      write_all(cw(2,2,0,0,2), 32'h9000, 32'hA000);
      rst_por_n = 1'b0;
      @(negedge clk);
      rst_por_n = 1'b1;
      chk("R10 ctl cleared by POR", 32'(ctl_rdata), 32'h0);
      fetch(32'h0, 1'b1, 1'b1, 1'b1);
      chk("R10 cmp regs zero after POR", {30'b0, hit_a, hit_b}, 32'h3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule